// File: doc/BRIEF.md
# GPIO Port with Change Interrupt

An eight-bit general-purpose I/O port built as a small register file behind a single-cycle read/write strobe interface. Software chooses per pin whether it is an input or an output, whether its sampled level is inverted, whether it has a pull-up, and whether it can raise an interrupt. An enabled pin raises an interrupt when its level changes from the previous sample, or, per pin, while its level differs from a stored reference bit.

Pins pass through a two-stage synchronizer before anything inspects them. When an enabled pin triggers, the port latches a per-pin flag word and a snapshot of the whole port as seen after polarity inversion. Both stay frozen, and the interrupt line stays asserted, until software reads the register picked as the acknowledge register. The interrupt line can be driven push-pull with either active level, or as an open-drain low-going output.

Top module: `gpio_ioc_port`

## Requirements
- R1: After reset the direction register reads 0xFF, so every pin is an input (`pinOe` = 0x00). Every other register reads 0x00, and the interrupt is inactive: `irqOe` = 1 and `irqOut` = 1.
- R2: Writes to indices 0x0 (direction), 0x1 (polarity), 0x2 (enable), 0x3 (reference), 0x4 (mode), 0x6 (pull-up) and 0xA (latch) read back unchanged. Index 0x5 (configuration) keeps bits 2:0 and reads the rest as 0. A direction bit of 1 makes the pin an input, so `pinOe` is the inverse of the direction register. `pullEn` equals the pull-up register.
- R3: `pinOut` equals the output latch, which is written at index 0xA or 0x9. A read of index 0x9 returns the pins after two flops, XOR the polarity register.
- R4: A pin whose mode bit is 0 and whose enable bit is 1 triggers when its inverted, synchronized level differs from the previous cycle's. The flag appears three clock edges after the pin changes.
- R5: A pin whose mode bit is 1 and whose enable bit is 1 triggers on every cycle that its inverted, synchronized level differs from its reference bit. It re-triggers after an acknowledge while the mismatch persists.
- R6: A trigger with nothing pending loads the flag register (index 0x7) with the triggering pins and loads the capture register (index 0x8) with the inverted port. While anything is pending, both registers are frozen and later triggers are dropped.
- R7: With configuration bit 0 = 0, a read of index 0x9 acknowledges. With configuration bit 0 = 1, a read of index 0x8 acknowledges instead. An acknowledge clears the flags. Reads of other indices do not clear them.
- R8: Configuration bit 2 = 1 selects open-drain drive: `irqOut` = 0 and `irqOe` = pending. Otherwise `irqOe` = 1 and `irqOut` is pending when bit 1 = 1, or its inverse when bit 1 = 0.
- R9: Pins with enable bit 0 never set a flag.
- R10: When an acknowledge and a new trigger fall in the same cycle, the new flags and snapshot replace the old ones and the interrupt stays asserted.
- R11: Writes to indices 0x7 and 0x8 are ignored. Reads of indices 0xB to 0xF return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for one cycle |
| rdEn | input | 1 | Read strobe for one cycle (drives acknowledge side effect) |
| addr | input | 4 | Register index |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr`, combinational |
| pinIn | input | 8 | Asynchronous pin levels |
| pinOut | output | 8 | Output latch levels |
| pinOe | output | 8 | Per-pin output enable |
| pullEn | output | 8 | Per-pin pull-up enable |
| irqOut | output | 1 | Interrupt drive level |
| irqOe | output | 1 | Interrupt drive enable |

## Verification
The acknowledge read and a fresh trigger can land on the same clock edge. The bench provokes this by timing a port read so that it meets the edge at which a synchronized pin change first becomes a trigger. It then judges the result by checking that the flag register holds only the new pin, that the capture holds the new port image, and that the interrupt never dropped. A cycle model built from the requirements runs beside the design under fixed-seed random register traffic and pin toggling, so other collisions are compared on every cycle as well.

// File: rtl/gpio_ioc_pkg.sv
package gpio_ioc_pkg;
  localparam int unsigned REG_ADDR_W = 4;
  localparam int unsigned CFG_W      = 3;
  localparam int unsigned CFG_CLRSEL = 0;  // acknowledge register select
  localparam int unsigned CFG_ACTHI  = 1;  // active-high interrupt level
  localparam int unsigned CFG_ODRAIN = 2;  // open-drain interrupt drive

  typedef enum logic [REG_ADDR_W-1:0] {
    IDX_DIR  = 4'h0,
    IDX_POL  = 4'h1,
    IDX_IEN  = 4'h2,
    IDX_REF  = 4'h3,
    IDX_MODE = 4'h4,
    IDX_CFG  = 4'h5,
    IDX_PULL = 4'h6,
    IDX_FLAG = 4'h7,
    IDX_CAP  = 4'h8,
    IDX_PORT = 4'h9,
    IDX_LAT  = 4'hA
  } regIdx_e;

  typedef struct packed {
    logic wrDir;
    logic wrPol;
    logic wrIen;
    logic wrRef;
    logic wrMode;
    logic wrCfg;
    logic wrPull;
    logic wrLat;
    logic clrPend;
  } strobe_t;
endpackage

// File: rtl/gpio_ioc_ctrl.sv
module gpio_ioc_ctrl
  import gpio_ioc_pkg::*;
(
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [CFG_W-1:0]      cfgBits,
  input  logic                  pending,
  output strobe_t               strb,
  output logic                  irqOut,
  output logic                  irqOe
);
  logic [REG_ADDR_W-1:0] ackIdx;

  assign ackIdx = cfgBits[CFG_CLRSEL] ? IDX_CAP : IDX_PORT;

  always_comb begin
    strb = '0;
    if (wrEn) begin
      case (addr)
        IDX_DIR:           strb.wrDir  = 1'b1;
        IDX_POL:           strb.wrPol  = 1'b1;
        IDX_IEN:           strb.wrIen  = 1'b1;
        IDX_REF:           strb.wrRef  = 1'b1;
        IDX_MODE:          strb.wrMode = 1'b1;
        IDX_CFG:           strb.wrCfg  = 1'b1;
        IDX_PULL:          strb.wrPull = 1'b1;
        IDX_PORT, IDX_LAT: strb.wrLat  = 1'b1;
        default:           ;
      endcase
    end
    strb.clrPend = rdEn && (addr == ackIdx);
  end

  always_comb begin
    if (cfgBits[CFG_ODRAIN]) begin
      irqOut = 1'b0;
      irqOe  = pending;
    end else begin
      irqOut = cfgBits[CFG_ACTHI] ? pending : !pending;
      irqOe  = 1'b1;
    end
  end
endmodule

// File: rtl/gpio_ioc_datapath.sv
module gpio_ioc_datapath
  import gpio_ioc_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strb,
  input  logic [WIDTH-1:0]      wrData,
  input  logic [REG_ADDR_W-1:0] rdAddr,
  input  logic [WIDTH-1:0]      pinIn,
  output logic [WIDTH-1:0]      rdData,
  output logic [WIDTH-1:0]      pinOut,
  output logic [WIDTH-1:0]      pinOe,
  output logic [WIDTH-1:0]      pullEn,
  output logic [CFG_W-1:0]      cfgBits,
  output logic                  pending,
  output logic [WIDTH-1:0]      capOut
);
  localparam int unsigned CFG_PAD = WIDTH - CFG_W;

  logic [SYNC_STAGES-1:0][WIDTH-1:0] syncQ;
  logic [WIDTH-1:0] dirR, polR, ienR, refR, modeR, pullR, latR;
  logic [WIDTH-1:0] flagR, capR, prevR;
  logic [CFG_W-1:0] cfgR;
  logic [WIDTH-1:0] effLvl, evt, trig;
  logic             anyTrig;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
  end

  assign effLvl = syncQ[SYNC_STAGES-1] ^ polR;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign evt[i] = modeR[i] ? (effLvl[i] ^ refR[i]) : (effLvl[i] ^ prevR[i]);
  end

  assign trig    = evt & ienR;
  assign anyTrig = |trig;
  assign pending = |flagR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirR  <= '1;
      polR  <= '0;
      ienR  <= '0;
      refR  <= '0;
      modeR <= '0;
      pullR <= '0;
      latR  <= '0;
      cfgR  <= '0;
      flagR <= '0;
      capR  <= '0;
      prevR <= '0;
    end else begin
      if (strb.wrDir)  dirR  <= wrData;
      if (strb.wrPol)  polR  <= wrData;
      if (strb.wrIen)  ienR  <= wrData;
      if (strb.wrRef)  refR  <= wrData;
      if (strb.wrMode) modeR <= wrData;
      if (strb.wrPull) pullR <= wrData;
      if (strb.wrLat)  latR  <= wrData;
      if (strb.wrCfg)  cfgR  <= wrData[CFG_W-1:0];
      prevR <= effLvl;
      if (anyTrig && (!pending || strb.clrPend)) begin
        flagR <= trig;
        capR  <= effLvl;
      end else if (strb.clrPend) begin
        flagR <= '0;
      end
    end
  end

  always_comb begin
    case (rdAddr)
      IDX_DIR:  rdData = dirR;
      IDX_POL:  rdData = polR;
      IDX_IEN:  rdData = ienR;
      IDX_REF:  rdData = refR;
      IDX_MODE: rdData = modeR;
      IDX_CFG:  rdData = {{CFG_PAD{1'b0}}, cfgR};
      IDX_PULL: rdData = pullR;
      IDX_FLAG: rdData = flagR;
      IDX_CAP:  rdData = capR;
      IDX_PORT: rdData = effLvl;
      IDX_LAT:  rdData = latR;
      default:  rdData = '0;
    endcase
  end

  assign pinOut  = latR;
  assign pinOe   = ~dirR;
  assign pullEn  = pullR;
  assign cfgBits = cfgR;
  assign capOut  = capR;
endmodule

// File: rtl/gpio_ioc_port.sv
module gpio_ioc_port
  import gpio_ioc_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]      wrData,
  output logic [WIDTH-1:0]      rdData,
  input  logic [WIDTH-1:0]      pinIn,
  output logic [WIDTH-1:0]      pinOut,
  output logic [WIDTH-1:0]      pinOe,
  output logic [WIDTH-1:0]      pullEn,
  output logic                  irqOut,
  output logic                  irqOe
);
  strobe_t          strb;
  logic [CFG_W-1:0] cfgBits;
  logic             pending;
  logic [WIDTH-1:0] capOut;

  gpio_ioc_ctrl u_ctrl (
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .addr    (addr),
    .cfgBits (cfgBits),
    .pending (pending),
    .strb    (strb),
    .irqOut  (irqOut),
    .irqOe   (irqOe)
  );

  gpio_ioc_datapath #(
    .WIDTH       (WIDTH),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (wrData),
    .rdAddr  (addr),
    .pinIn   (pinIn),
    .rdData  (rdData),
    .pinOut  (pinOut),
    .pinOe   (pinOe),
    .pullEn  (pullEn),
    .cfgBits (cfgBits),
    .pending (pending),
    .capOut  (capOut)
  );
endmodule

// File: rtl/gpio_ioc_port_chk.sv
module gpio_ioc_port_chk
  import gpio_ioc_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic                  rdEn,
  input logic [REG_ADDR_W-1:0] addr,
  input logic [WIDTH-1:0]      wrData,
  input logic [WIDTH-1:0]      pinOut,
  input logic [WIDTH-1:0]      pinOe,
  input logic                  irqOut,
  input logic                  irqOe,
  input logic                  pending,
  input logic [CFG_W-1:0]      cfgBits,
  input logic [WIDTH-1:0]      capOut
);
  logic ackRead;
  assign ackRead = rdEn && (addr == (cfgBits[CFG_CLRSEL] ? IDX_CAP : IDX_PORT));

  AST_RESET_INPUTS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pinOe == '0)) else $error("pins not inputs after reset"); // R1

  AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == IDX_DIR) |=> (pinOe == ~$past(wrData))) else $error("direction write"); // R2

  AST_LATCH_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (addr == IDX_LAT || addr == IDX_PORT)) |=> (pinOut == $past(wrData))) else $error("latch write"); // R3

  AST_CAPTURE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !ackRead) |=> (pending && $stable(capOut))) else $error("capture moved while pending"); // R6

  AST_OPEN_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    cfgBits[CFG_ODRAIN] |-> (!irqOut && (irqOe == pending))) else $error("open-drain drive"); // R8

  AST_PUSH_PULL: assert property (@(posedge clk) disable iff (!rstN)
    !cfgBits[CFG_ODRAIN] |-> (irqOe && (irqOut == (cfgBits[CFG_ACTHI] ? pending : !pending))))
    else $error("push-pull drive"); // R8
endmodule

bind gpio_ioc_port gpio_ioc_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .rdEn    (rdEn),
  .addr    (addr),
  .wrData  (wrData),
  .pinOut  (pinOut),
  .pinOe   (pinOe),
  .irqOut  (irqOut),
  .irqOe   (irqOe),
  .pending (pending),
  .cfgBits (cfgBits),
  .capOut  (capOut)
);

// File: tb/tb_gpio_ioc_port.sv
module tb_gpio_ioc_port;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0, pinIn = '0;
  logic [7:0] rdData, pinOut, pinOe, pullEn;
  logic       irqOut, irqOe;

  int nChk = 0, nErr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_ioc_port dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .pullEn(pullEn), .irqOut(irqOut), .irqOe(irqOe)
  );

  // Reference model built from the requirements
  logic [7:0] mDir, mPol, mIen, mRef, mMode, mPull, mLat, mFlag, mCap, mS1, mS2, mPrev;
  logic [2:0] mCfg;
  logic [7:0] mEff, mEvt, mTrig;
  logic       mClr;

  always @(posedge clk) begin
    if (!rstN) begin
      mDir = 8'hFF; mPol = 0; mIen = 0; mRef = 0; mMode = 0; mPull = 0; mLat = 0;
      mFlag = 0; mCap = 0; mS1 = 0; mS2 = 0; mPrev = 0; mCfg = 0;
    end else begin
      mEff = mS2 ^ mPol;
      for (int i = 0; i < 8; i++)
        mEvt[i] = mMode[i] ? (mEff[i] != mRef[i]) : (mEff[i] != mPrev[i]);
      mTrig = mEvt & mIen;
      mClr  = rdEn && (addr == (mCfg[0] ? 4'h8 : 4'h9));
      if (mTrig != 0 && (mFlag == 0 || mClr)) begin
        mFlag = mTrig; mCap = mEff;
      end else if (mClr) mFlag = 0;
      mPrev = mEff; mS2 = mS1; mS1 = pinIn;
      if (wrEn) begin
        case (addr)
          4'h0: mDir = wrData;
          4'h1: mPol = wrData;
          4'h2: mIen = wrData;
          4'h3: mRef = wrData;
          4'h4: mMode = wrData;
          4'h5: mCfg = wrData[2:0];
          4'h6: mPull = wrData;
          4'h9, 4'hA: mLat = wrData;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [7:0] expRd(input logic [3:0] a);
    case (a)
      4'h0: return mDir;
      4'h1: return mPol;
      4'h2: return mIen;
      4'h3: return mRef;
      4'h4: return mMode;
      4'h5: return {5'b0, mCfg};
      4'h6: return mPull;
      4'h7: return mFlag;
      4'h8: return mCap;
      4'h9: return mS2 ^ mPol;
      4'hA: return mLat;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [1:0] expIrq();
    logic p = (mFlag != 0);
    if (mCfg[2]) return {p, 1'b0};
    return {1'b1, mCfg[1] ? p : !p};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    string rdTag;
    rdTag = (addr == 4'h9) ? "R3 port read" :
            (addr == 4'h7 || addr == 4'h8) ? "R6 flag/capture read" :
            (addr > 4'hA) ? "R11 unused read" : "R2 register read";
    check(rdTag, rdData, expRd(addr));
    check("R8 irq drive", {6'b0, irqOe, irqOut}, {6'b0, expIrq()});
    check("R3 pinOut", pinOut, mLat);
    check("R2 pinOe", pinOe, ~mDir);
    check("R2 pullEn", pullEn, mPull);
  endtask

  task automatic cyc(input logic w, input logic r, input logic [3:0] a,
                     input logic [7:0] d, input logic [7:0] p);
    @(negedge clk);
    wrEn = w; rdEn = r; addr = a; wrData = d; pinIn = p;
    #1 compareAll();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset state
    cyc(0, 0, 4'h0, 0, 0);
    check("R1 dir reset", rdData, 8'hFF);
    check("R1 oe reset", pinOe, 8'h00);
    check("R1 irq idle", {6'b0, irqOe, irqOut}, 8'h03);

    // R2 / R3 direction and latch
    cyc(1, 0, 4'h0, 8'h0F, 0);
    cyc(1, 0, 4'hA, 8'hA5, 0);
    cyc(0, 0, 4'h0, 0, 0);
    check("R2 oe", pinOe, 8'hF0);
    check("R3 latch drive", pinOut, 8'hA5);
    cyc(1, 0, 4'h6, 8'h5A, 0);
    cyc(0, 0, 4'h6, 0, 0);
    check("R2 pull readback", rdData, 8'h5A);
    cyc(1, 0, 4'h5, 8'hFA, 0);
    cyc(0, 0, 4'h5, 0, 0);
    check("R2 cfg width", rdData, 8'h02);
    cyc(1, 0, 4'h5, 8'h00, 0);

    // R3 sync + polarity, R9 disabled pins
    cyc(1, 0, 4'h1, 8'h01, 8'h3C);
    cyc(0, 0, 4'h9, 0, 8'h3C);
    cyc(0, 0, 4'h9, 0, 8'h3C);
    check("R3 port inverted", rdData, 8'h3D);
    cyc(0, 0, 4'h7, 0, 8'h3C);
    check("R9 no flag when disabled", rdData, 8'h00);
    check("R9 irq idle", {7'b0, irqOut}, 8'h01);

    // R4 change mode, R6 capture
    cyc(1, 0, 4'h2, 8'hFF, 8'h3C);
    cyc(0, 0, 4'h7, 0, 8'h3C);
    cyc(0, 0, 4'h7, 0, 8'h7C);
    cyc(0, 0, 4'h7, 0, 8'h7C);
    cyc(0, 0, 4'h7, 0, 8'h7C);
    check("R4 not before third edge", rdData, 8'h00);
    cyc(0, 0, 4'h7, 0, 8'h7C);
    check("R4 change flag", rdData, 8'h40);
    check("R8 active-low asserted", {7'b0, irqOut}, 8'h00);
    cyc(0, 0, 4'h8, 0, 8'h7C);
    check("R6 capture", rdData, 8'h7D);
    // R6 frozen while pending
    for (int k = 0; k < 4; k++) cyc(0, 0, 4'h7, 0, 8'h5C);
    check("R6 flags frozen", rdData, 8'h40);
    cyc(0, 0, 4'h8, 0, 8'h5C);
    check("R6 capture frozen", rdData, 8'h7D);

    // R7 acknowledge selection
    cyc(0, 1, 4'h8, 0, 8'h5C);
    cyc(0, 0, 4'h7, 0, 8'h5C);
    check("R7 capture read does not ack", rdData, 8'h40);
    cyc(0, 1, 4'h9, 0, 8'h5C);
    cyc(0, 0, 4'h7, 0, 8'h5C);
    check("R7 port read acks", rdData, 8'h00);
    check("R7 irq released", {7'b0, irqOut}, 8'h01);
    cyc(1, 0, 4'h5, 8'h01, 8'h5C);
    for (int k = 0; k < 4; k++) cyc(0, 0, 4'h7, 0, 8'h5E);
    check("R7 pending before ack", rdData, 8'h02);
    cyc(0, 1, 4'h9, 0, 8'h5E);
    cyc(0, 0, 4'h7, 0, 8'h5E);
    check("R7 port read ignored when bit0=1", rdData, 8'h02);
    cyc(0, 1, 4'h8, 0, 8'h5E);
    cyc(0, 0, 4'h7, 0, 8'h5E);
    check("R7 capture read acks when bit0=1", rdData, 8'h00);

    // R10 ack and trigger in the same cycle
    cyc(1, 0, 4'h5, 8'h00, 8'h5E);
    for (int k = 0; k < 4; k++) cyc(0, 0, 4'h7, 0, 8'h5A);
    check("R10 first event", rdData, 8'h04);
    cyc(0, 0, 4'h7, 0, 8'h52);
    cyc(0, 0, 4'h7, 0, 8'h52);
    cyc(0, 1, 4'h9, 0, 8'h52);
    cyc(0, 0, 4'h7, 0, 8'h52);
    check("R10 new flags win", rdData, 8'h08);
    check("R10 irq held", {7'b0, irqOut}, 8'h00);
    cyc(0, 0, 4'h8, 0, 8'h52);
    check("R10 new capture", rdData, 8'h53);
    cyc(0, 1, 4'h9, 0, 8'h52);

    // R5 compare mode
    cyc(1, 0, 4'h2, 8'h80, 8'h52);
    cyc(1, 0, 4'h4, 8'h80, 8'h52);
    cyc(1, 0, 4'h3, 8'h00, 8'h52);
    cyc(0, 1, 4'h9, 0, 8'h52);
    for (int k = 0; k < 4; k++) cyc(0, 0, 4'h7, 0, 8'hD2);
    check("R5 mismatch flag", rdData, 8'h80);
    cyc(0, 1, 4'h9, 0, 8'hD2);
    cyc(0, 0, 4'h7, 0, 8'hD2);
    check("R5 re-trigger while mismatch", rdData, 8'h80);
    // R11 ignored writes
    cyc(1, 0, 4'h7, 8'hFF, 8'hD2);
    cyc(1, 0, 4'h8, 8'h00, 8'hD2);
    cyc(0, 0, 4'h7, 0, 8'hD2);
    check("R11 flag write ignored", rdData, 8'h80);
    cyc(0, 0, 4'h8, 0, 8'hD2);
    check("R11 capture write ignored", rdData, 8'hD3);
    cyc(0, 0, 4'hC, 0, 8'hD2);
    check("R11 unused index", rdData, 8'h00);
    cyc(1, 0, 4'h3, 8'h80, 8'hD2);
    cyc(0, 1, 4'h9, 0, 8'hD2);
    cyc(0, 0, 4'h7, 0, 8'hD2);
    check("R5 release on match", rdData, 8'h00);

    // R8 drive styles
    cyc(1, 0, 4'h5, 8'h02, 8'hD2);
    cyc(0, 0, 4'h0, 0, 8'hD2);
    check("R8 active-high idle", {6'b0, irqOe, irqOut}, 8'h02);
    cyc(1, 0, 4'h5, 8'h04, 8'hD2);
    cyc(0, 0, 4'h0, 0, 8'hD2);
    check("R8 open-drain idle", {6'b0, irqOe, irqOut}, 8'h00);
    cyc(1, 0, 4'h3, 8'h00, 8'hD2);
    cyc(0, 0, 4'h0, 0, 8'hD2);
    cyc(0, 0, 4'h0, 0, 8'hD2);
    check("R8 open-drain asserted", {6'b0, irqOe, irqOut}, 8'h02);

    // Random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] p;
      p = (($urandom % 4) == 0) ? 8'($urandom) : pinIn;
      cyc(($urandom % 4) == 0, ($urandom % 3) == 0, 4'($urandom % 13), 8'($urandom), p);
    end

    summary();
    $finish;
  end
endmodule